// File: doc/BRIEF.md
# Pin DAC Level Source Selector

This block sits beside one output pin that carries an 8-bit DAC. It holds a per-pin configuration word, written through a strobe and data bus. From that word it decides where the DAC level code comes from and whether the DAC output is enabled. Four level sources exist:

- a static level stored in the configuration;
- one byte lane of a shared processor DAC bus, with the processor picked by a select field;
- a level computed by the pin's own smart-mode engine;
- a single OUT bit that switches between zero and the static level.

The level code, the enable and the 2-bit range select are registered on the system clock. The analog DAC and the ADC sit downstream and are outside this block. The range select is only passed through.

Some configuration bits change meaning with the smart-mode field. The 2-bit control field selects processor-bus sourcing when no smart mode runs. When a smart mode runs, bit 0 of that field forces the DAC enable on.

The configuration word is 20 bits wide, with these fields:

| Bits | Field |
|------|-------|
| [7:0] | static level |
| [9:8] | range |
| [12:10] | DAC tag |
| [14:13] | control |
| [19:15] | smart-mode |

Top module: `pin_dac_source_sel`

## Requirements
- R1: While reset is high, and on the first edge after it, dac_level is 0, dac_enable is 0 and dac_range is 0. The configuration word is cleared to 0.
- R2: A configuration word presented with cfg_we high is stored at that clock edge. Outputs reflect it on the following edge. Data presented with cfg_we low is not stored.
- R3: When the DAC tag field (bits [12:10]) is not 3'b101, dac_level and dac_enable are 0, whatever the other inputs are.
- R4: With the tag at 3'b101, smart-mode field 0 and control 2'b00, dac_level is the static level (bits [7:0]) and dac_enable follows dir_in.
- R5: With smart-mode field 0 and control 2'b01, the low 4 bits of the static level select processor p. dac_level is bits [p*32 + PIN_LANE*8 +: 8] of proc_dac, so lane 0 is bits 7:0 and lane 1 is bits 15:8. A select of NUM_PROCS or more gives 0. dac_enable follows dir_in.
- R6: With the smart-mode field 1, 2 or 3, dac_level equals smart_level and the static level has no effect.
- R7: With the smart-mode field 4 or above, or with field 0 and control bit 1 set, dac_level is 0 when out_in is 0 and is the static level when out_in is 1.
- R8: When the smart-mode field is non-zero, dac_enable is dir_in OR control bit 0. When the field is zero, control bit 0 does not force the enable.
- R9: dac_level and dac_enable change on the clock edge after their source input changes.
- R10: dac_range carries the range field (bits [9:8]) when the tag is 3'b101 and is 0 otherwise, with the same one-edge delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 20 | Configuration word to store |
| dir_in | input | 1 | Pin direction control |
| out_in | input | 1 | Pin output bit |
| proc_dac | input | NUM_PROCS*LANES*8 | Shared processor DAC buses, one 32-bit group per processor |
| smart_level | input | 8 | Level computed by the smart-mode engine |
| dac_level | output | 8 | Registered DAC level code |
| dac_enable | output | 1 | Registered DAC output enable |
| dac_range | output | 2 | Registered range select |

## Verification
The bench builds the block with NUM_PROCS set to 3 and PIN_LANE set to 2. Under those values, processor selects 3 to 15 exercise the out-of-range rule that returns 0. Lane extraction is checked away from bit 0, so an offset error cannot hide. Every smart-mode class and every control field value is driven with random DIR, OUT, bus and engine values, and configuration data is presented with the strobe low.

// File: rtl/pin_dac_pkg.sv
package pin_dac_pkg;

    localparam int LVL_W   = 8;
    localparam int RANGE_W = 2;
    localparam int TAG_W   = 3;
    localparam int CTRL_W  = 2;
    localparam int SMODE_W = 5;
    localparam int SEL_W   = 4;
    localparam int CFG_W   = LVL_W + RANGE_W + TAG_W + CTRL_W + SMODE_W;

    localparam logic [TAG_W-1:0]   DAC_TAG       = 3'b101;
    localparam logic [SMODE_W-1:0] SMODE_LAST_ENG = 5'd3;

    typedef struct packed {
        logic [SMODE_W-1:0] smode;
        logic [CTRL_W-1:0]  ctrl;
        logic [TAG_W-1:0]   tag;
        logic [RANGE_W-1:0] range;
        logic [LVL_W-1:0]   level;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        SRC_OFF,
        SRC_STATIC,
        SRC_PROC,
        SRC_ENGINE,
        SRC_BIT
    } dac_src_e;

    typedef struct packed {
        dac_src_e src;
        logic     dac_on;
        logic     force_en;
    } src_sel_t;

    function automatic src_sel_t decode_cfg(pin_cfg_t c);
        src_sel_t r;
        r.dac_on   = (c.tag == DAC_TAG);
        r.force_en = 1'b0;
        r.src      = SRC_OFF;
        if (r.dac_on) begin
            if (c.smode == '0) begin
                if (c.ctrl[1])       r.src = SRC_BIT;
                else if (c.ctrl[0])  r.src = SRC_PROC;
                else                 r.src = SRC_STATIC;
            end else begin
                r.force_en = c.ctrl[0];
                r.src      = (c.smode <= SMODE_LAST_ENG) ? SRC_ENGINE : SRC_BIT;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pin_dac_cfg_reg.sv
module pin_dac_cfg_reg
    import pin_dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output pin_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= pin_cfg_t'(wdata);
    end
endmodule

// File: rtl/pin_dac_mode_dec.sv
module pin_dac_mode_dec
    import pin_dac_pkg::*;
(
    input  pin_cfg_t cfg,
    output src_sel_t sel
);
    always_comb sel = decode_cfg(cfg);
endmodule

// File: rtl/pin_dac_lane_pick.sv
module pin_dac_lane_pick
    import pin_dac_pkg::*;
#(
    parameter int NUM_PROCS = 4,
    parameter int LANES     = 4,
    parameter int PIN_LANE  = 0,
    localparam int GROUP_W  = LANES * LVL_W,
    localparam int BUS_W    = NUM_PROCS * GROUP_W
)(
    input  logic [BUS_W-1:0] bus,
    input  logic [SEL_W-1:0] proc_sel,
    output logic [LVL_W-1:0] lane
);
    logic [LVL_W-1:0] picked [NUM_PROCS];

    for (genvar p = 0; p < NUM_PROCS; p++) begin : g_proc
        assign picked[p] = bus[p*GROUP_W + PIN_LANE*LVL_W +: LVL_W];
    end

    always_comb begin
        lane = '0;
        for (int p = 0; p < NUM_PROCS; p++) begin
            if (proc_sel == SEL_W'(p)) lane = picked[p];
        end
    end
endmodule

// File: rtl/pin_dac_source_sel.sv
module pin_dac_source_sel
    import pin_dac_pkg::*;
#(
    parameter int NUM_PROCS = 4,
    parameter int LANES     = 4,
    parameter int PIN_LANE  = 0,
    localparam int BUS_W    = NUM_PROCS * LANES * LVL_W
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               dir_in,
    input  logic               out_in,
    input  logic [BUS_W-1:0]   proc_dac,
    input  logic [LVL_W-1:0]   smart_level,
    output logic [LVL_W-1:0]   dac_level,
    output logic               dac_enable,
    output logic [RANGE_W-1:0] dac_range
);
    pin_cfg_t         cfg_q;
    src_sel_t         sel;
    logic [LVL_W-1:0] bus_lane;
    logic [LVL_W-1:0] level_d;
    logic             enable_d;
    logic [RANGE_W-1:0] range_d;

    pin_dac_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    pin_dac_mode_dec u_dec (
        .cfg (cfg_q),
        .sel (sel)
    );

    pin_dac_lane_pick #(
        .NUM_PROCS (NUM_PROCS),
        .LANES     (LANES),
        .PIN_LANE  (PIN_LANE)
    ) u_pick (
        .bus      (proc_dac),
        .proc_sel (cfg_q.level[SEL_W-1:0]),
        .lane     (bus_lane)
    );

    always_comb begin
        unique case (sel.src)
            SRC_STATIC: level_d = cfg_q.level;
            SRC_PROC:   level_d = bus_lane;
            SRC_ENGINE: level_d = smart_level;
            SRC_BIT:    level_d = out_in ? cfg_q.level : '0;
            default:    level_d = '0;
        endcase
        enable_d = sel.dac_on & (dir_in | sel.force_en);
        range_d  = sel.dac_on ? cfg_q.range : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_level  <= '0;
            dac_enable <= 1'b0;
            dac_range  <= '0;
        end else begin
            dac_level  <= level_d;
            dac_enable <= enable_d;
            dac_range  <= range_d;
        end
    end
endmodule

// File: rtl/pin_dac_source_sel_chk.sv
module pin_dac_source_sel_chk
    import pin_dac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             dir_in,
    input logic             out_in,
    input logic [LVL_W-1:0] smart_level,
    input pin_cfg_t         cfg_q,
    input logic [LVL_W-1:0] dac_level,
    input logic             dac_enable
);
    logic tag_ok, eng_mode, bit_mode;
    assign tag_ok   = (cfg_q.tag == 3'b101);
    assign eng_mode = tag_ok && cfg_q.smode != '0 && cfg_q.smode < 5'd4;
    assign bit_mode = tag_ok && (cfg_q.smode >= 5'd4 || (cfg_q.smode == '0 && cfg_q.ctrl[1]));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (dac_level == '0 && !dac_enable));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we)) |-> $stable(cfg_q));

    assert_no_tag_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(tag_ok) |-> (dac_level == '0 && !dac_enable));

    assert_engine_level_R6: assert property (@(posedge clk) disable iff (rst)
        $past(eng_mode) |-> dac_level == $past(smart_level));

    assert_bit_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $past(bit_mode && !out_in) |-> dac_level == '0);

    assert_force_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $past(tag_ok && cfg_q.smode != '0 && cfg_q.ctrl[0]) |-> dac_enable);

    assert_dir_follow_R9: assert property (@(posedge clk) disable iff (rst)
        $past(tag_ok && cfg_q.smode == '0) |-> dac_enable == $past(dir_in));
endmodule

bind pin_dac_source_sel pin_dac_source_sel_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .dir_in      (dir_in),
    .out_in      (out_in),
    .smart_level (smart_level),
    .cfg_q       (cfg_q),
    .dac_level   (dac_level),
    .dac_enable  (dac_enable)
);

// File: tb/test_pin_dac_source_sel.sv
module test_pin_dac_source_sel;
    localparam int NP    = 3;
    localparam int LN    = 4;
    localparam int PL    = 2;
    localparam int BUS_W = NP * LN * 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [19:0]      cfg_wdata = '0;
    logic             dir_in = 1'b0;
    logic             out_in = 1'b0;
    logic [BUS_W-1:0] proc_dac = '0;
    logic [7:0]       smart_level = '0;
    logic [7:0]       dac_level;
    logic             dac_enable;
    logic [1:0]       dac_range;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_dac_source_sel #(.NUM_PROCS(NP), .LANES(LN), .PIN_LANE(PL)) i_pin_dac_source_sel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dir_in(dir_in), .out_in(out_in), .proc_dac(proc_dac),
        .smart_level(smart_level), .dac_level(dac_level),
        .dac_enable(dac_enable), .dac_range(dac_range)
    );

    // behavioural reference model, updated at every rising edge
    logic [19:0] mcfg = '0;
    logic [7:0]  exp_lvl;
    logic        exp_en;
    logic [1:0]  exp_rng;
    string       lvl_tag, en_tag;
    bit          fresh = 1'b0;

    always @(posedge clk) begin
        logic [4:0] sm;
        logic [1:0] ct;
        int         sel;
        sm = mcfg[19:15];
        ct = mcfg[14:13];
        sel = int'(mcfg[3:0]);
        if (rst) begin
            exp_lvl = 0; exp_en = 0; exp_rng = 0;
            lvl_tag = "R1"; en_tag = "R1";
        end else if (mcfg[12:10] != 3'b101) begin
            exp_lvl = 0; exp_en = 0; exp_rng = 0;
            lvl_tag = "R3"; en_tag = "R3";
        end else begin
            exp_rng = mcfg[9:8];
            if (sm == 0) begin
                exp_en = dir_in;
                if (ct == 2'b00) begin
                    exp_lvl = mcfg[7:0]; lvl_tag = "R4";
                end else if (ct == 2'b01) begin
                    exp_lvl = (sel < NP) ? proc_dac[sel*32 + PL*8 +: 8] : 8'h00;
                    lvl_tag = "R5";
                end else begin
                    exp_lvl = out_in ? mcfg[7:0] : 8'h00; lvl_tag = "R7";
                end
                en_tag = "R4 R5 R8";
            end else begin
                exp_en = dir_in | ct[0];
                en_tag = "R8";
                if (sm <= 3) begin
                    exp_lvl = smart_level; lvl_tag = "R6";
                end else begin
                    exp_lvl = out_in ? mcfg[7:0] : 8'h00; lvl_tag = "R7";
                end
            end
        end
        if (fresh) begin lvl_tag = {lvl_tag, " R2"}; en_tag = {en_tag, " R2"}; end
        fresh = 1'b0;
        if (rst) mcfg = '0;
        else if (cfg_we) begin mcfg = cfg_wdata; fresh = 1'b1; end
        #2;
        checks += 3;
        if (dac_level !== exp_lvl) begin
            errors++;
            $display("FAIL %s R9 level: actual %0h expected %0h", lvl_tag, dac_level, exp_lvl);
        end
        if (dac_enable !== exp_en) begin
            errors++;
            $display("FAIL %s enable: actual %0b expected %0b", en_tag, dac_enable, exp_en);
        end
        if (dac_range !== exp_rng) begin
            errors++;
            $display("FAIL R10 range: actual %0d expected %0d", dac_range, exp_rng);
        end
    end

    task automatic jiggle();
        @(negedge clk);
        cfg_we      = 1'b0;
        cfg_wdata   = 20'($urandom());   // presented without strobe: must be ignored (R2)
        dir_in      = 1'($urandom());
        out_in      = 1'($urandom());
        smart_level = 8'($urandom());
        for (int p = 0; p < NP; p++) proc_dac[p*32 +: 32] = $urandom();
    endtask

    task automatic write_cfg(input logic [4:0] sm, input logic [1:0] ct,
                             input logic [2:0] tg, input logic [1:0] rg,
                             input logic [7:0] lv, input int cycles);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {sm, ct, tg, rg, lv};
        for (int i = 0; i < cycles; i++) jiggle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R3: tag other than 101 keeps the DAC idle
        write_cfg(5'd0, 2'b00, 3'b100, 2'b11, 8'hA5, 20);
        write_cfg(5'd2, 2'b01, 3'b000, 2'b01, 8'h3C, 20);
        // R4 static, R10 range
        write_cfg(5'd0, 2'b00, 3'b101, 2'b10, 8'hDE, 30);
        write_cfg(5'd0, 2'b00, 3'b101, 2'b01, 8'h00, 10);
        // R5 every processor select, including out of range
        for (int s = 0; s < 16; s++)
            write_cfg(5'd0, 2'b01, 3'b101, 2'(s), {4'hF, 4'(s)}, 12);
        // R6 engine modes with and without forced enable (R8)
        for (int m = 1; m <= 3; m++) begin
            write_cfg(5'(m), 2'b00, 3'b101, 2'b00, 8'h77, 20);
            write_cfg(5'(m), 2'b01, 3'b101, 2'b11, 8'h11, 20);
            write_cfg(5'(m), 2'b10, 3'b101, 2'b10, 8'hF0, 10);
        end
        // R7 OUT bit mode, both entry paths
        write_cfg(5'd0, 2'b10, 3'b101, 2'b01, 8'hC3, 30);
        write_cfg(5'd0, 2'b11, 3'b101, 2'b10, 8'h5A, 30);
        write_cfg(5'd4, 2'b00, 3'b101, 2'b00, 8'h81, 30);
        write_cfg(5'd31, 2'b01, 3'b101, 2'b11, 8'hFF, 30);
        write_cfg(5'd17, 2'b11, 3'b101, 2'b01, 8'h24, 30);
        // back-to-back writes (R2)
        write_cfg(5'd0, 2'b00, 3'b101, 2'b00, 8'h12, 0);
        write_cfg(5'd0, 2'b00, 3'b101, 2'b11, 8'h34, 0);
        write_cfg(5'd0, 2'b00, 3'b010, 2'b11, 8'h56, 5);
        // reset again mid run (R1)
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (5) jiggle();
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule